// File: doc/BRIEF.md
# USB Endpoint Flag and Configuration Register File

This block holds the register state that a device-side USB controller exposes for each of its endpoints. A small CPU register port reaches one endpoint at a time. A select register picks the endpoint, and every per-endpoint address then lands on that endpoint's copy of the control, the two configuration registers, the status register, the interrupt flag register and the interrupt enable register. A read-only summary register collects one bit per endpoint, and a single level-sensitive interrupt request covers all endpoints.

The packet buffer logic, which is outside this block, reports events as one-cycle set pulses for each endpoint and flag, and as overflow and underflow pulses. It also gives steady full and empty levels for each endpoint buffer. The block decides which bits software may change. Flags can only be cleared, and only by writing 0. The read/write-allowed flag is never stored. It is computed from the endpoint direction and the buffer level whenever it is observed. Writing the second configuration register presets the handshake flags so that firmware can start the endpoint.

The CPU port is a plain register interface and not a stream. A write takes effect on the clock edge where `cpu_we` is high. Read data is combinational from `cpu_addr`, and a read has no side effect. Event inputs have no back-pressure: every pulse is taken in the cycle it occurs. When an event and a CPU write hit the same bit in the same cycle, the event wins.

Top module: `usb_ep_regfile`

Register addresses (`cpu_addr`): 0 endpoint select, 1 control, 2 config A, 3 config B, 4 status, 5 flags, 6 interrupt enable, 7 summary (read-only).

Flag bits:

| Bit | Flag |
|-----|------|
| 0 | tx ready |
| 1 | OUT received |
| 2 | SETUP received |
| 3 | stalled |
| 4 | NAK-out |
| 5 | read/write allowed (computed) |
| 6 | NAK-in |
| 7 | FIFO control |

Each enable bit gates the flag at the same position. Enable bit 5 is the flow-error enable.

Other register bits:

| Register | Bit | Meaning |
|----------|-----|---------|
| Status | 7 | configuration OK |
| Status | 6 | overflow |
| Status | 5 | underflow |
| Config A | 0 | direction (1 = IN) |
| Config A | 7:6 | type (0 = control) |
| Config B | 1 | allocate |
| Control | 0 | endpoint enable |

## Requirements
- R1: A CPU write to the flag register clears each stored flag whose written bit is 0. Writing 1 never sets a flag.
- R2: Clearing SETUP received (bit 2 currently 1, written 0) also clears OUT received (bit 1). Writing 0 to bit 2 while it is already 0 leaves bit 1 unchanged.
- R3: Flag bit 5 reads as "buffer not full" for an IN endpoint (config A bit 0 = 1) and as "buffer not empty" for an OUT endpoint. CPU writes to that bit have no effect.
- R4: A set pulse raises the flag one cycle later. `ep_irq` is high only while some endpoint has a raised flag (bit 5 excluded) whose enable bit at the same position is set.
- R5: Any flag set pulse (bit 5 excluded), overflow pulse or underflow pulse sets that endpoint's summary bit. A CPU flag write that leaves all flags of the endpoint, bit 5 ignored, at zero clears the summary bit.
- R6: Overflow and underflow pulses set status bits 6 and 5. They request `ep_irq` only when enable bit 5 is set. Writing 0 clears them, and writing 1 has no effect. Status bits 4..0 and bit 7 are not CPU-writable.
- R7: Writing config A clears configuration OK (status bit 7). Writing config B loads configuration OK from the written bit 1.
- R8: A config B write sets tx ready on a control endpoint, sets tx ready and FIFO control on an IN endpoint, and clears OUT received in every case.
- R9: Control bit 0 of each endpoint drives that endpoint's `ep_enable` output.
- R10: Select writes with values 0 to NEP-1 are taken and others are ignored. All per-endpoint addresses reach only the selected endpoint.
- R11: After reset all registers, `ep_summary` and `ep_irq` are zero, and the select register is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| cpu_we | input | 1 | register write strobe |
| cpu_addr | input | 3 | register address |
| cpu_wdata | input | 8 | write data |
| cpu_rdata | output | 8 | combinational read data |
| evt_flag_set | input | NEP*8 | flag set pulses, endpoint i at bits [8i+7:8i] |
| evt_ovf | input | NEP | overflow pulse per endpoint |
| evt_unf | input | NEP | underflow pulse per endpoint |
| buf_full | input | NEP | buffer full level per endpoint |
| buf_empty | input | NEP | buffer empty level per endpoint |
| ep_enable | output | NEP | control bit 0 of each endpoint |
| ep_summary | output | NEP | endpoint interrupt summary |
| ep_irq | output | 1 | shared endpoint interrupt request |

## Verification
Register writes, set pulses, and the summary and status effects become visible one clock edge after the cycle in which they are driven. `ep_irq` follows that registered state combinationally, so it changes in the same cycle. Bit 5 and `cpu_rdata` respond to `buf_full`, `buf_empty` and `cpu_addr` with no clock at all. The bench therefore drives every stimulus just after a falling edge and holds it through exactly one rising edge. It reads back one nanosecond after setting the address, so each check samples a settled value, one edge after its cause.

// File: rtl/usb_epreg_pkg.sv
package usb_epreg_pkg;
  localparam int DW = 8;

  typedef enum logic [2:0] {
    A_SEL  = 3'd0,
    A_CTRL = 3'd1,
    A_CFGA = 3'd2,
    A_CFGB = 3'd3,
    A_STAT = 3'd4,
    A_FLAG = 3'd5,
    A_IEN  = 3'd6,
    A_SUM  = 3'd7
  } reg_addr_e;

  localparam int F_TXRDY = 0;
  localparam int F_OUTRX = 1;
  localparam int F_SETUP = 2;
  localparam int F_RWOK  = 5;
  localparam int F_FIFOC = 7;

  localparam int S_UNF   = 5;
  localparam int S_OVF   = 6;
  localparam int S_CFGOK = 7;

  localparam int CA_DIR  = 0;
  localparam int CA_TYLO = 6;
  localparam int CB_ALLOC = 1;

  localparam logic [DW-1:0] FLAG_SUM_MASK = 8'hDF;
  localparam logic [DW-1:0] STAT_FLOW_MASK = 8'h60;
endpackage

// File: rtl/epr_slot.sv
module epr_slot
  import usb_epreg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] evt_set,
  input  logic          evt_ovf,
  input  logic          evt_unf,
  input  logic          buf_full,
  input  logic          buf_empty,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] cfga_q,
  output logic [DW-1:0] cfgb_q,
  output logic [DW-1:0] stat_q,
  output logic [DW-1:0] flag_q,
  output logic [DW-1:0] flag_view,
  output logic [DW-1:0] ien_q,
  output logic          irq_req,
  output logic          sum_set,
  output logic          sum_clr
);
  logic [DW-1:0] flag_n, stat_n;
  logic wr_flag, wr_cfga, wr_cfgb, wr_stat, is_in, is_ctl;

  assign wr_flag = wr_en && (wr_addr == A_FLAG);
  assign wr_cfga = wr_en && (wr_addr == A_CFGA);
  assign wr_cfgb = wr_en && (wr_addr == A_CFGB);
  assign wr_stat = wr_en && (wr_addr == A_STAT);
  assign is_in   = cfga_q[CA_DIR];
  assign is_ctl  = (cfga_q[CA_TYLO+1:CA_TYLO] == 2'b00);

  always_comb begin
    flag_n = flag_q;
    stat_n = stat_q;
    if (wr_flag) begin
      flag_n = flag_q & wdata;
      if (flag_q[F_SETUP] && !wdata[F_SETUP]) flag_n[F_OUTRX] = 1'b0;
    end
    if (wr_cfga) stat_n[S_CFGOK] = 1'b0;
    if (wr_cfgb) begin
      stat_n[S_CFGOK] = wdata[CB_ALLOC];
      if (is_ctl) begin
        flag_n[F_TXRDY] = 1'b1;
      end else if (is_in) begin
        flag_n[F_TXRDY] = 1'b1;
        flag_n[F_FIFOC] = 1'b1;
      end
      flag_n[F_OUTRX] = 1'b0;
    end
    if (wr_stat) stat_n = stat_q & (wdata | ~STAT_FLOW_MASK);
    stat_n[S_OVF] = stat_n[S_OVF] | evt_ovf;
    stat_n[S_UNF] = stat_n[S_UNF] | evt_unf;
    stat_n = stat_n & (STAT_FLOW_MASK | 8'h80);
    flag_n = (flag_n | evt_set) & FLAG_SUM_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cfga_q <= '0;
      cfgb_q <= '0;
      stat_q <= '0;
      flag_q <= '0;
      ien_q  <= '0;
    end else begin
      if (wr_en && wr_addr == A_CTRL) ctrl_q <= wdata;
      if (wr_cfga) cfga_q <= wdata;
      if (wr_cfgb) cfgb_q <= wdata;
      if (wr_en && wr_addr == A_IEN) ien_q <= wdata;
      stat_q <= stat_n;
      flag_q <= flag_n;
    end
  end

  always_comb begin
    flag_view = flag_q;
    flag_view[F_RWOK] = is_in ? !buf_full : !buf_empty;
  end

  assign irq_req = (|(flag_q & ien_q & FLAG_SUM_MASK))
                 | (ien_q[F_RWOK] & (|(stat_q & STAT_FLOW_MASK)));
  assign sum_set = (|(evt_set & FLAG_SUM_MASK)) | evt_ovf | evt_unf;
  assign sum_clr = wr_flag && ((flag_n & FLAG_SUM_MASK) == '0);
endmodule

// File: rtl/epr_irqsum.sv
module epr_irqsum #(
  parameter int NEP = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEP-1:0] sum_set,
  input  logic [NEP-1:0] sum_clr,
  input  logic [NEP-1:0] irq_req,
  output logic [NEP-1:0] sum_q,
  output logic           irq
);
  for (genvar i = 0; i < NEP; i++) begin : g_sum
    always_ff @(posedge clk) begin
      if (!rst_n)          sum_q[i] <= 1'b0;
      else if (sum_set[i]) sum_q[i] <= 1'b1;
      else if (sum_clr[i]) sum_q[i] <= 1'b0;
    end
  end
  assign irq = |irq_req;
endmodule

// File: rtl/epr_rdmux.sv
module epr_rdmux
  import usb_epreg_pkg::*;
#(
  parameter int NEP  = 5,
  parameter int SELW = 3
) (
  input  logic [2:0]              addr,
  input  logic [SELW-1:0]         sel,
  input  logic [NEP-1:0][DW-1:0]  ctrl,
  input  logic [NEP-1:0][DW-1:0]  cfga,
  input  logic [NEP-1:0][DW-1:0]  cfgb,
  input  logic [NEP-1:0][DW-1:0]  stat,
  input  logic [NEP-1:0][DW-1:0]  flag,
  input  logic [NEP-1:0][DW-1:0]  ien,
  input  logic [NEP-1:0]          sum,
  output logic [DW-1:0]           rdata
);
  always_comb begin
    rdata = '0;
    unique case (addr)
      A_SEL:  rdata = DW'(sel);
      A_CTRL: rdata = ctrl[sel];
      A_CFGA: rdata = cfga[sel];
      A_CFGB: rdata = cfgb[sel];
      A_STAT: rdata = stat[sel];
      A_FLAG: rdata = flag[sel];
      A_IEN:  rdata = ien[sel];
      A_SUM:  rdata = DW'(sum);
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/usb_ep_regfile.sv
module usb_ep_regfile
  import usb_epreg_pkg::*;
#(
  parameter int NEP = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_we,
  input  logic [2:0]       cpu_addr,
  input  logic [7:0]       cpu_wdata,
  output logic [7:0]       cpu_rdata,
  input  logic [NEP*8-1:0] evt_flag_set,
  input  logic [NEP-1:0]   evt_ovf,
  input  logic [NEP-1:0]   evt_unf,
  input  logic [NEP-1:0]   buf_full,
  input  logic [NEP-1:0]   buf_empty,
  output logic [NEP-1:0]   ep_enable,
  output logic [NEP-1:0]   ep_summary,
  output logic             ep_irq
);
  localparam int SELW = (NEP > 1) ? $clog2(NEP) : 1;
  localparam logic [DW-1:0] NEP_LIM = DW'(NEP);

  logic [SELW-1:0] sel_q;
  logic [NEP-1:0][DW-1:0] ctrl_st, cfga_st, cfgb_st, stat_st, flag_st, view_st, ien_st;
  logic [NEP-1:0] irq_v, set_v, clr_v;

  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= '0;
    else if (cpu_we && cpu_addr == A_SEL && cpu_wdata < NEP_LIM)
      sel_q <= cpu_wdata[SELW-1:0];
  end

  for (genvar i = 0; i < NEP; i++) begin : g_ep
    logic wr_here;
    assign wr_here = cpu_we && (sel_q == SELW'(i));
    epr_slot u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_here),
      .wr_addr   (cpu_addr),
      .wdata     (cpu_wdata),
      .evt_set   (evt_flag_set[i*8 +: 8]),
      .evt_ovf   (evt_ovf[i]),
      .evt_unf   (evt_unf[i]),
      .buf_full  (buf_full[i]),
      .buf_empty (buf_empty[i]),
      .ctrl_q    (ctrl_st[i]),
      .cfga_q    (cfga_st[i]),
      .cfgb_q    (cfgb_st[i]),
      .stat_q    (stat_st[i]),
      .flag_q    (flag_st[i]),
      .flag_view (view_st[i]),
      .ien_q     (ien_st[i]),
      .irq_req   (irq_v[i]),
      .sum_set   (set_v[i]),
      .sum_clr   (clr_v[i])
    );
    assign ep_enable[i] = ctrl_st[i][0];
  end

  epr_irqsum #(.NEP(NEP)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .sum_set (set_v),
    .sum_clr (clr_v),
    .irq_req (irq_v),
    .sum_q   (ep_summary),
    .irq     (ep_irq)
  );

  epr_rdmux #(.NEP(NEP), .SELW(SELW)) u_rd (
    .addr  (cpu_addr),
    .sel   (sel_q),
    .ctrl  (ctrl_st),
    .cfga  (cfga_st),
    .cfgb  (cfgb_st),
    .stat  (stat_st),
    .flag  (view_st),
    .ien   (ien_st),
    .sum   (ep_summary),
    .rdata (cpu_rdata)
  );
endmodule

// File: rtl/epr_checker.sv
module epr_checker
  import usb_epreg_pkg::*;
#(
  parameter int NEP  = 5,
  parameter int SELW = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cpu_we,
  input logic [2:0]             cpu_addr,
  input logic [7:0]             cpu_wdata,
  input logic [SELW-1:0]        sel_q,
  input logic [NEP*8-1:0]       evt_flag_set,
  input logic [NEP-1:0]         evt_ovf,
  input logic [NEP-1:0][DW-1:0] flag_st,
  input logic [NEP-1:0][DW-1:0] stat_st,
  input logic [NEP-1:0][DW-1:0] ien_st,
  input logic [NEP-1:0]         ep_summary,
  input logic                   ep_irq
);
  localparam logic [SELW-1:0] SEL_LIM = SELW'(NEP);

  p_sel_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q < SEL_LIM);

  p_irq_needs_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ep_irq |-> (ien_st != '0));

  for (genvar i = 0; i < NEP; i++) begin : g_chk
    logic flag_wr;
    assign flag_wr = cpu_we && cpu_addr == A_FLAG && sel_q == SELW'(i);

    p_write1_noset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_wr && evt_flag_set[i*8 +: 8] == 8'h00)
        |=> ((flag_st[i] & ~$past(flag_st[i])) == 8'h00));

    p_setup_clears_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_wr && flag_st[i][F_SETUP] && !cpu_wdata[F_SETUP] && !evt_flag_set[i*8+F_OUTRX])
        |=> !flag_st[i][F_OUTRX]);

    p_summary_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((evt_flag_set[i*8 +: 8] & FLAG_SUM_MASK) != 8'h00) |=> ep_summary[i]);

    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_st[i][S_OVF] && !(cpu_we && cpu_addr == A_STAT && sel_q == SELW'(i) && !cpu_wdata[S_OVF]))
        |=> stat_st[i][S_OVF]);

    p_ovf_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      evt_ovf[i] |=> stat_st[i][S_OVF]);
  end
endmodule

bind usb_ep_regfile epr_checker #(.NEP(NEP), .SELW(SELW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_we       (cpu_we),
  .cpu_addr     (cpu_addr),
  .cpu_wdata    (cpu_wdata),
  .sel_q        (sel_q),
  .evt_flag_set (evt_flag_set),
  .evt_ovf      (evt_ovf),
  .flag_st      (flag_st),
  .stat_st      (stat_st),
  .ien_st       (ien_st),
  .ep_summary   (ep_summary),
  .ep_irq       (ep_irq)
);

// File: tb/usb_ep_regfile_tb_top.sv
`timescale 1ns/1ps
module usb_ep_regfile_tb_top;
  localparam int NEP = 5;
  localparam logic [2:0] A_SEL = 3'd0, A_CTRL = 3'd1, A_CFGA = 3'd2, A_CFGB = 3'd3,
                         A_STAT = 3'd4, A_FLAG = 3'd5, A_IEN = 3'd6, A_SUM = 3'd7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_we = 1'b0;
  logic [2:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic [NEP*8-1:0] evt_flag_set = '0;
  logic [NEP-1:0] evt_ovf = '0, evt_unf = '0, buf_full = '0, buf_empty = '1;
  logic [NEP-1:0] ep_enable, ep_summary;
  logic ep_irq;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  usb_ep_regfile #(.NEP(NEP)) dut_i (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    cpu_addr = a;
    #1;
    d = cpu_rdata;
  endtask

  task automatic pulse(input int ep, input logic [7:0] f, input bit ovf, input bit unf);
    @(negedge clk);
    evt_flag_set[ep*8 +: 8] = f; evt_ovf[ep] = ovf; evt_unf[ep] = unf;
    @(negedge clk);
    evt_flag_set = '0; evt_ovf = '0; evt_unf = '0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(A_SEL, v);  chk("R11 select", v, 8'h00);
    rd(A_FLAG, v); chk("R11 flags", v, 8'h00);
    rd(A_STAT, v); chk("R11 status", v, 8'h00);
    rd(A_SUM, v);  chk("R11 summary", v, 8'h00);
    chk("R11 irq", {7'd0, ep_irq}, 8'h00);
    chk("R11 enable", {3'd0, ep_enable}, 8'h00);
  endtask

  task automatic t_select();
    logic [7:0] v;
    wr(A_SEL, 8'd3); rd(A_SEL, v); chk("R10 take 3", v, 8'd3);
    wr(A_SEL, 8'd7); rd(A_SEL, v); chk("R10 ignore 7", v, 8'd3);
    wr(A_CTRL, 8'h01);
    chk("R9 enable ep3", {3'd0, ep_enable}, 8'h08);
    wr(A_SEL, 8'd2); rd(A_CTRL, v); chk("R10 routing ctrl ep2", v, 8'h00);
    wr(A_SEL, 8'd4); rd(A_SEL, v); chk("R10 take max", v, 8'd4);
    wr(A_SEL, 8'd5); rd(A_SEL, v); chk("R10 ignore NEP", v, 8'd4);
  endtask

  task automatic t_cfg();
    logic [7:0] v;
    wr(A_SEL, 8'd1);
    wr(A_CFGA, 8'h81);
    wr(A_CFGB, 8'h02);
    rd(A_STAT, v); chk("R7 cfg ok set", v, 8'h80);
    rd(A_FLAG, v); chk("R8 IN preset", v, 8'hA1);
    wr(A_CFGA, 8'h81);
    rd(A_STAT, v); chk("R7 cfgA clears ok", v, 8'h00);
    wr(A_CFGB, 8'h00);
    rd(A_STAT, v); chk("R7 alloc 0", v, 8'h00);
    wr(A_SEL, 8'd2);
    wr(A_CFGA, 8'h00);
    pulse(2, 8'h02, 1'b0, 1'b0);
    rd(A_FLAG, v); chk("R8 out set before", v, 8'h02);
    wr(A_CFGB, 8'h02);
    rd(A_FLAG, v); chk("R8 control preset clears out", v, 8'h01);
    rd(A_STAT, v); chk("R7 ep2 ok", v, 8'h80);
  endtask

  task automatic t_flag_clear();
    logic [7:0] v;
    wr(A_SEL, 8'd0);
    pulse(0, 8'hC8, 1'b0, 1'b0);
    rd(A_FLAG, v); chk("R4 set pulse", v, 8'hC8);
    wr(A_FLAG, 8'hFF); rd(A_FLAG, v); chk("R1 write ones", v, 8'hC8);
    wr(A_FLAG, 8'h7F); rd(A_FLAG, v); chk("R1 clear bit7", v, 8'h48);
    wr(A_FLAG, 8'h00); rd(A_FLAG, v); chk("R1 clear all", v, 8'h00);
  endtask

  task automatic t_setup();
    logic [7:0] v;
    pulse(0, 8'h06, 1'b0, 1'b0);
    wr(A_FLAG, 8'hFD); rd(A_FLAG, v); chk("R2 out only", v, 8'h04);
    wr(A_FLAG, 8'hFB); rd(A_FLAG, v); chk("R2 setup clear", v, 8'h00);
    pulse(0, 8'h06, 1'b0, 1'b0);
    wr(A_FLAG, 8'hFB); rd(A_FLAG, v); chk("R2 setup clears out", v, 8'h00);
    pulse(0, 8'h02, 1'b0, 1'b0);
    wr(A_FLAG, 8'hFB); rd(A_FLAG, v); chk("R2 setup already 0", v, 8'h02);
    wr(A_FLAG, 8'h00);
  endtask

  task automatic t_rwok();
    logic [7:0] v;
    wr(A_SEL, 8'd0);
    buf_empty[0] = 1'b0;
    rd(A_FLAG, v); chk("R3 OUT not empty", v, 8'h20);
    wr(A_FLAG, 8'h00); rd(A_FLAG, v); chk("R3 write ignored", v, 8'h20);
    buf_empty[0] = 1'b1;
    rd(A_FLAG, v); chk("R3 OUT empty", v, 8'h00);
    wr(A_SEL, 8'd1);
    buf_full[1] = 1'b1;
    rd(A_FLAG, v); chk("R3 IN full", v, 8'h81);
    buf_full[1] = 1'b0;
    rd(A_FLAG, v); chk("R3 IN not full", v, 8'hA1);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    wr(A_SEL, 8'd3);
    pulse(3, 8'h02, 1'b0, 1'b0);
    chk("R5 summary set", {7'd0, ep_summary[3]}, 8'h01);
    chk("R4 no enable no irq", {7'd0, ep_irq}, 8'h00);
    wr(A_IEN, 8'h02);
    chk("R4 irq enabled", {7'd0, ep_irq}, 8'h01);
    rd(A_SUM, v); chk("R5 summary reg bit3", v & 8'h08, 8'h08);
    wr(A_FLAG, 8'h00);
    chk("R5 summary cleared", {7'd0, ep_summary[3]}, 8'h00);
    chk("R4 irq drops", {7'd0, ep_irq}, 8'h00);
  endtask

  task automatic t_sum_bit5();
    logic [7:0] v;
    wr(A_SEL, 8'd4);
    buf_empty[4] = 1'b0;
    pulse(4, 8'h12, 1'b0, 1'b0);
    wr(A_FLAG, 8'hEF); rd(A_FLAG, v); chk("R1 partial", v, 8'h22);
    chk("R5 summary held", {7'd0, ep_summary[4]}, 8'h01);
    wr(A_FLAG, 8'h00); rd(A_FLAG, v); chk("R3 bit5 stays", v, 8'h20);
    chk("R5 bit5 ignored", {7'd0, ep_summary[4]}, 8'h00);
    buf_empty[4] = 1'b1;
  endtask

  task automatic t_flow();
    logic [7:0] v;
    wr(A_SEL, 8'd2);
    pulse(2, 8'h00, 1'b1, 1'b0);
    rd(A_STAT, v); chk("R6 overflow", v, 8'hC0);
    chk("R6 no flow enable", {7'd0, ep_irq}, 8'h00);
    wr(A_STAT, 8'hFF); rd(A_STAT, v); chk("R6 write ones", v, 8'hC0);
    wr(A_STAT, 8'h00); rd(A_STAT, v); chk("R6 clear keeps ok", v, 8'h80);
    pulse(2, 8'h00, 1'b0, 1'b1);
    rd(A_STAT, v); chk("R6 underflow", v, 8'hA0);
    wr(A_IEN, 8'h20);
    chk("R6 flow irq", {7'd0, ep_irq}, 8'h01);
    wr(A_STAT, 8'h1F); rd(A_STAT, v); chk("R6 low bits ro", v, 8'h80);
    chk("R6 irq drops", {7'd0, ep_irq}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_select();
    t_cfg();
    t_flag_clear();
    t_setup();
    t_rwok();
    t_irq();
    t_sum_bit5();
    t_flow();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule